// File: doc/BRIEF.md
# Byte, Halfword and Bit Reversal Unit

This block rearranges a 64-bit integer operand by reversing lanes inside fixed groups. It handles bytes inside halfwords, words or the full doubleword, halfwords inside words or the doubleword, and bits inside bytes, the low word or the doubleword. It also sign-extends a narrow byte or halfword. A 5-bit minor opcode selects the operation. That opcode is the field an integer pipeline's decoder has already isolated from the register-to-register instruction group.

Three of the operations produce a 32-bit result, and the block sign-extends that result from bit 31 to fill the 64-bit output. An opcode the block does not implement raises an illegal flag and forces the result to zero. By default the datapath is purely combinational. A parameter can add one register stage on the output.

Top module: `bitperm_unit`

## Requirements
- R1: Opcode 5'b01101 swaps the two bytes of each of the four halfwords (result byte i = operand byte i XOR 1).
- R2: Opcode 5'b01100 swaps the two bytes of each of the two low halfwords and sign-extends the 32-bit result from bit 31.
- R3: Opcode 5'b01110 reverses the byte order inside each 32-bit word (result byte i = operand byte i XOR 3).
- R4: Opcode 5'b01111 reverses the order of all eight bytes (result byte i = operand byte 7-i).
- R5: Opcode 5'b10000 exchanges the two halfwords of each 32-bit word.
- R6: Opcode 5'b10001 reverses the order of the four halfwords.
- R7: Opcode 5'b10010 reverses the bits inside each of the low four bytes and sign-extends the 32-bit result from bit 31.
- R8: Opcode 5'b10011 reverses the bits inside each of the eight bytes (result bit i = operand bit i XOR 7).
- R9: Opcode 5'b10100 reverses the low 32 bits and sign-extends the result from bit 31.
- R10: Opcode 5'b10101 reverses all 64 bits (result bit i = operand bit 63-i).
- R11: Opcode 5'b10110 sign-extends operand bits [15:0]. Opcode 5'b10111 sign-extends operand bits [7:0].
- R12: Every opcode outside 5'b01100 to 5'b10111 sets illegal_o to 1 with result_o zero. Every opcode inside that range clears illegal_o.
- R13: With REG_OUT = 0, result_o and illegal_o follow opcode_i and operand_i in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, used by the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| opcode_i | input | 5 | Minor opcode selecting the operation |
| operand_i | input | 64 | Source operand |
| result_o | output | 64 | Rearranged or extended result |
| illegal_o | output | 1 | Opcode not handled by this unit |

## Verification
Every one of the 32 opcodes is applied to each operand pattern and compared against an index-XOR reference. An ascending nibble ramp and its descending mirror give every byte and nibble a distinct value, so any two lane permutations produce different results. Single set bits at positions 7, 15, 31 and 63 show which bit drives sign extension and confirm that the full-width operations ignore bit 31. Zero, all-ones and pseudo-random operands cover the remaining data space, including the zeroed result on illegal opcodes.

// File: rtl/perm_pkg.sv
package perm_pkg;
  localparam int XLEN     = 64;
  localparam int HALF_W   = XLEN / 2;
  localparam int OPC_W    = 5;
  localparam int N_OPS    = 12;
  localparam int N_REV    = 8;
  localparam logic [OPC_W-1:0] OP_FIRST = 5'b01100;

  typedef enum logic [OPC_W-1:0] {
    OP_BSWAP_H2 = 5'b01100,
    OP_BSWAP_H4 = 5'b01101,
    OP_BSWAP_W2 = 5'b01110,
    OP_BSWAP_D  = 5'b01111,
    OP_HSWAP_W2 = 5'b10000,
    OP_HSWAP_D  = 5'b10001,
    OP_BREV_B4  = 5'b10010,
    OP_BREV_B8  = 5'b10011,
    OP_BREV_W   = 5'b10100,
    OP_BREV_D   = 5'b10101,
    OP_SEXT_H   = 5'b10110,
    OP_SEXT_B   = 5'b10111
  } perm_op_e;

  typedef struct packed {
    logic             legal;
    logic             narrow;
    logic [N_OPS-1:0] sel;
  } perm_ctl_t;

  // lane width and group width of each reversal network
  localparam int REV_LANE  [N_REV] = '{8, 8, 8, 16, 16, 1, 1, 1};
  localparam int REV_GROUP [N_REV] = '{16, 32, 64, 32, 64, 8, 32, 64};
endpackage

// File: rtl/perm_decode.sv
module perm_decode
  import perm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opcode_i,
  output perm_ctl_t        ctl_o
);
  logic [OPC_W-1:0] op_off;

  assign op_off = opcode_i - OP_FIRST;

  always_comb begin
    ctl_o = '0;
    if (opcode_i >= OP_BSWAP_H2 && opcode_i <= OP_SEXT_B) begin
      ctl_o.legal = 1'b1;
      ctl_o.sel   = N_OPS'(1) << op_off;
    end
    // 32-bit result variants sign-extend from bit 31
    ctl_o.narrow = (opcode_i == OP_BSWAP_H2) || (opcode_i == OP_BREV_B4) ||
                   (opcode_i == OP_BREV_W);
  end

  // R12
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ctl_o.sel) && (ctl_o.legal == (ctl_o.sel != '0)));
endmodule

// File: rtl/perm_lane_rev.sv
module perm_lane_rev #(
  parameter int W     = 64,
  parameter int LANE  = 8,
  parameter int GROUP = 16
) (
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int N_GRP  = W / GROUP;
  localparam int N_LANE = GROUP / LANE;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    for (genvar l = 0; l < N_LANE; l++) begin : g_lane
      assign q_o[g*GROUP + l*LANE +: LANE] =
             d_i[g*GROUP + (N_LANE-1-l)*LANE +: LANE];
    end
  end
endmodule

// File: rtl/bitperm_unit.sv
module bitperm_unit
  import perm_pkg::*;
#(
  parameter bit REG_OUT = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [XLEN-1:0]  operand_i,
  output logic [XLEN-1:0]  result_o,
  output logic             illegal_o
);
  perm_ctl_t       ctl;
  logic [XLEN-1:0] rev   [N_REV];
  logic [XLEN-1:0] cand  [N_OPS];
  logic [XLEN-1:0] wide;
  logic [XLEN-1:0] res_d;
  logic            ill_d;

  perm_decode u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .opcode_i(opcode_i),
    .ctl_o   (ctl)
  );

  for (genvar k = 0; k < N_REV; k++) begin : g_rev
    perm_lane_rev #(
      .W    (XLEN),
      .LANE (REV_LANE[k]),
      .GROUP(REV_GROUP[k])
    ) u_rev (
      .d_i(operand_i),
      .q_o(rev[k])
    );
  end

  // candidate order follows opcode order from OP_FIRST
  assign cand[0]  = rev[0];
  assign cand[1]  = rev[0];
  assign cand[2]  = rev[1];
  assign cand[3]  = rev[2];
  assign cand[4]  = rev[3];
  assign cand[5]  = rev[4];
  assign cand[6]  = rev[5];
  assign cand[7]  = rev[5];
  assign cand[8]  = rev[6];
  assign cand[9]  = rev[7];
  assign cand[10] = {{(XLEN-16){operand_i[15]}}, operand_i[15:0]};
  assign cand[11] = {{(XLEN-8){operand_i[7]}}, operand_i[7:0]};

  always_comb begin
    wide = '0;
    for (int k = 0; k < N_OPS; k++) begin
      if (ctl.sel[k]) wide = wide | cand[k];
    end
  end

  assign res_d = ctl.narrow ? {{HALF_W{wide[HALF_W-1]}}, wide[HALF_W-1:0]} : wide;
  assign ill_d = !ctl.legal;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        result_o  <= '0;
        illegal_o <= 1'b0;
      end else begin
        result_o  <= res_d;
        illegal_o <= ill_d;
      end
    end
  end else begin : g_comb
    assign result_o  = res_d;
    assign illegal_o = ill_d;
  end

  // R12
  illegal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ill_d |-> (res_d == '0));

  // R2 R7 R9
  narrow_sext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == OP_BSWAP_H2 || opcode_i == OP_BREV_B4 || opcode_i == OP_BREV_W)
    |-> (res_d[XLEN-1:HALF_W] == {HALF_W{res_d[HALF_W-1]}}));

  // R11
  sext_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == OP_SEXT_H) |->
    (res_d[15:0] == operand_i[15:0] && res_d[XLEN-1:16] == {(XLEN-16){operand_i[15]}}));

  // R1 R3 R4 R5 R6 R8 R10
  perm_weight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == OP_BSWAP_H4 || opcode_i == OP_BSWAP_W2 || opcode_i == OP_BSWAP_D ||
     opcode_i == OP_HSWAP_W2 || opcode_i == OP_HSWAP_D || opcode_i == OP_BREV_B8 ||
     opcode_i == OP_BREV_D)
    |-> ($countones(res_d) == $countones(operand_i)));
endmodule

// File: tb/bitperm_unit_tb.sv
module bitperm_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  opcode;
  logic [63:0] operand;
  logic [63:0] result;
  logic        illegal;
  int          n_chk = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  bitperm_unit u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .opcode_i (opcode),
    .operand_i(operand),
    .result_o (result),
    .illegal_o(illegal)
  );

  function automatic string req_of(input logic [4:0] op);
    case (op)
      5'b01100: return "R2";
      5'b01101: return "R1";
      5'b01110: return "R3";
      5'b01111: return "R4";
      5'b10000: return "R5";
      5'b10001: return "R6";
      5'b10010: return "R7";
      5'b10011: return "R8";
      5'b10100: return "R9";
      5'b10101: return "R10";
      5'b10110, 5'b10111: return "R11";
      default: return "R12";
    endcase
  endfunction

  // result = operand with bit index XOR mask, inside a chosen width, then extension
  function automatic logic [64:0] ref_model(input logic [4:0] op, input logic [63:0] x);
    logic [63:0] r = '0;
    int mask = 0;
    int width = 64;
    bit ill = 0;
    case (op)
      5'b01100: begin mask = 8;  width = 32; end
      5'b01101: mask = 8;
      5'b01110: mask = 24;
      5'b01111: mask = 56;
      5'b10000: mask = 16;
      5'b10001: mask = 48;
      5'b10010: begin mask = 7;  width = 32; end
      5'b10011: mask = 7;
      5'b10100: begin mask = 31; width = 32; end
      5'b10101: mask = 63;
      5'b10110: mask = -1;
      5'b10111: mask = -2;
      default:  ill = 1;
    endcase
    if (ill) return {1'b1, 64'd0};
    if (mask == -1) return {1'b0, {48{x[15]}}, x[15:0]};
    if (mask == -2) return {1'b0, {56{x[7]}}, x[7:0]};
    for (int i = 0; i < width; i++) r[i] = x[i ^ mask];
    if (width == 32) for (int i = 32; i < 64; i++) r[i] = r[31];
    return {1'b0, r};
  endfunction

  task automatic check(input string req, input logic [63:0] exp_r, input logic exp_i);
    n_chk++;
    if (result !== exp_r || illegal !== exp_i) begin
      n_fail++;
      $display("FAIL %s op=%b opnd=%h : got res=%h ill=%b, exp res=%h ill=%b",
               req, opcode, operand, result, illegal, exp_r, exp_i);
    end
  endtask

  task automatic apply(input logic [4:0] op, input logic [63:0] x);
    logic [64:0] e;
    @(negedge clk);
    opcode  = op;
    operand = x;
    e = ref_model(op, x);
    #5;
    check(req_of(op), e[63:0], e[64]);
  endtask

  initial begin
    #4_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] pats [10];
    logic [63:0] lfsr = 64'hACE1_2468_BDF0_1357;
    logic [64:0] e;
    pats[0] = 64'h0123_4567_89AB_CDEF;
    pats[1] = 64'hFEDC_BA98_7654_3210;
    pats[2] = 64'h0;
    pats[3] = '1;
    pats[4] = 64'h0000_0000_8000_0001;
    pats[5] = 64'h8000_0000_0000_0080;
    pats[6] = 64'h0000_0000_0000_7F80;
    pats[7] = 64'h0000_0000_0000_8000;
    pats[8] = 64'h0000_0001_0000_0000;
    pats[9] = 64'h8000_0000_7FFF_FF7F;
    opcode  = 5'd0;
    operand = 64'h0;
    // R12 reset state: opcode 0 is illegal, result zero
    #15;
    check("R12", 64'h0, 1'b1);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    for (int p = 0; p < 10; p++)
      for (int op = 0; op < 32; op++) apply(5'(op), pats[p]);
    for (int k = 0; k < 20; k++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      for (int op = 0; op < 32; op++) apply(5'(op), lfsr);
    end
    // R13: result follows a change of inputs with no clock edge in between
    @(posedge clk);
    #2;
    opcode  = 5'b10101;
    operand = 64'h0000_0000_0000_0001;
    e = ref_model(opcode, operand);
    #1;
    check("R13", e[63:0], e[64]);
    opcode = 5'b01111;
    e = ref_model(opcode, operand);
    #1;
    check("R13", e[63:0], e[64]);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule